// File: doc/BRIEF.md
# Strip Byte Stream Formatter

The formatter receives strip hits as a byte-wide stream in which an address byte and a data byte take turns, and each byte comes with a flag marking it as corrupted. Every address/data pair is packed together with both flags into an 18-bit strip word. The word is then screened against a per-address bad-strip table, which drops words from damaged strips. For strips that pass, the raw data byte is replaced by the compensated value held for that address in a second table. Surviving words go into a dual-clock FIFO, which a clustering stage empties from its own, slower clock.

Both tables are loaded through a small host port (select, address, data, write enable). They can only be changed between events. An event opens with a start pulse, which also restarts byte pairing, and closes with an end pulse.

Top module: `strip_fmt_top`

## Requirements
- R1: After reset the FIFO reads empty and not full, the drop counter is zero, and every table entry is zero (good strip, compensated value 0).
- R2: The first valid byte after reset, after a completed pair, or in the same cycle as a start pulse is taken as an address. The next valid byte is its data. A start pulse with no valid byte throws away an address that is waiting for its data.
- R3: A strip word carries the address error flag in bit 17, the address in bits 16:9, the data error flag in bit 8 and the data in bits 7:0.
- R4: A pair whose address has its bad-strip entry set produces no word.
- R5: A forwarded word carries its own address and both error flags unchanged. Its bits 7:0 hold the compensated-value entry for that address in place of the received data.
- R6: Words leave the FIFO in the order their pairs were completed. While the empty flag is low, the read port shows the oldest word, and a read request removes it.
- R7: A word that arrives while the full flag is high is discarded. The drop counter then rises by one and holds at its maximum value.
- R8: With the host write enable high, select 0 writes bit 0 of the host data into the bad-strip entry and select 1 writes the whole byte into the compensated-value entry. The write is ignored from a start pulse up to and including the end pulse cycle.
- R9: A read request while the FIFO is empty changes nothing.
- R10: Cycles with the byte-valid input low do not count as bytes and do not advance the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Byte-stream clock |
| wr_rst_n | input | 1 | Active-low reset, byte-stream domain |
| ev_start | input | 1 | Event start pulse; restarts pairing and locks the tables |
| ev_end | input | 1 | Event end pulse; unlocks the tables |
| in_valid | input | 1 | A byte is present this cycle |
| in_byte | input | 8 | Stream byte (address or data) |
| in_err | input | 1 | Error flag of the present byte |
| tbl_we | input | 1 | Host table write enable |
| tbl_sel | input | 1 | 0 = bad-strip table, 1 = compensated-value table |
| tbl_addr | input | 8 | Host table address |
| tbl_wdata | input | 8 | Host table data |
| wr_full | output | 1 | FIFO full, byte-stream domain |
| ovf_count | output | CNT_W | Saturating count of words dropped while full |
| rd_clk | input | 1 | Clustering-side clock |
| rd_rst_n | input | 1 | Active-low reset, clustering domain |
| rd_en | input | 1 | Read request |
| rd_word | output | 18 | Oldest strip word, valid while rd_empty is low |
| rd_empty | output | 1 | FIFO empty, clustering domain |

## Verification
Two cases can land in the same cycle. A start pulse can coincide with a stream byte, and that byte must then open a fresh pair even when an address is already waiting. A start pulse can also coincide with a host table write, which must be refused because the lock takes effect in that same cycle. The bench drives each coincidence on purpose. It then sends strips whose expected words differ depending on which byte was paired and which table value was in force. A behavioural model predicts every word, and the words seen at the read port are compared with its queue, together with hand-computed final words and word counts.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              addr_err;
        logic [BYTE_W-1:0] addr;
        logic              data_err;
        logic [BYTE_W-1:0] data;
    } strip_word_t;

    localparam int WORD_W = $bits(strip_word_t);
endpackage

// File: rtl/sbf_pair.sv
module sbf_pair
    import sbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_err,
    output logic              out_vld,
    output strip_word_t       out_word
);
    typedef struct packed {
        logic              have_addr;
        logic              aerr;
        logic [BYTE_W-1:0] addr;
        logic              vld;
        strip_word_t       word;
    } pair_st_t;

    pair_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            if (ev_start || !st_q.have_addr) begin
                st_d.have_addr = 1'b1;
                st_d.addr      = in_byte;
                st_d.aerr      = in_err;
            end else begin
                st_d.have_addr = 1'b0;
                st_d.vld       = 1'b1;
                st_d.word      = '{addr_err: st_q.aerr, addr: st_q.addr,
                                   data_err: in_err, data: in_byte};
            end
        end else if (ev_start) begin
            st_d.have_addr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_word = st_q.word;

    // R2: a byte that comes with a start pulse is an address, so no word follows
    p_start_is_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && in_valid) |=> !out_vld);

    // R2: a finished pair is always followed by a fresh address byte
    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);
endmodule

// File: rtl/sbf_screen.sv
module sbf_screen
    import sbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_end,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [BYTE_W-1:0] tbl_addr,
    input  logic [BYTE_W-1:0] tbl_wdata,
    input  logic              in_vld,
    input  strip_word_t       in_word,
    output logic              push,
    output strip_word_t       push_word
);
    localparam int STRIPS = 1 << BYTE_W;

    typedef struct packed {
        logic                           active;
        logic [STRIPS-1:0]              bad;
        logic [STRIPS-1:0][BYTE_W-1:0]  gain;
        logic                           push;
        strip_word_t                    word;
    } scr_st_t;

    scr_st_t st_d, st_q;

    // raw data byte is superseded by the compensated table value
    logic unused_raw;
    assign unused_raw = ^in_word.data;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        if (ev_start)    st_d.active = 1'b1;
        else if (ev_end) st_d.active = 1'b0;
        if (tbl_we && !st_q.active && !ev_start) begin
            if (tbl_sel) st_d.gain[tbl_addr] = tbl_wdata;
            else         st_d.bad[tbl_addr]  = tbl_wdata[0];
        end
        if (in_vld && !st_q.bad[in_word.addr]) begin
            st_d.push      = 1'b1;
            st_d.word      = in_word;
            st_d.word.data = st_q.gain[in_word.addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push      = st_q.push;
    assign push_word = st_q.word;

    // R4: a word from a marked strip never reaches the FIFO
    p_bad_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && st_q.bad[in_word.addr]) |=> !push);

    // R8: tables are frozen while an event is open
    p_tables_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && tbl_we) |=> ($stable(st_q.gain) && $stable(st_q.bad)));
endmodule

// File: rtl/sbf_afifo.sv
module sbf_afifo #(
    parameter int W     = 18,
    parameter int AW    = 3,
    parameter int CNT_W = 8
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic             full,
    output logic [CNT_W-1:0] ovf_cnt,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic             empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           bin;
        logic [PW-1:0]           gray;
        logic [PW-1:0]           rs1;
        logic [PW-1:0]           rs2;
        logic                    full;
        logic [CNT_W-1:0]        ovf;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] ws1;
        logic [PW-1:0] ws2;
        logic          empty;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    always_comb begin
        w_d     = w_q;
        w_d.rs1 = r_q.gray;
        w_d.rs2 = w_q.rs1;
        if (wr_en) begin
            if (w_q.full) begin
                if (w_q.ovf != '1) w_d.ovf = w_q.ovf + CNT_W'(1);
            end else begin
                w_d.mem[w_q.bin[AW-1:0]] = wr_data;
                w_d.bin                  = w_q.bin + PW'(1);
            end
        end
        w_d.gray = to_gray(w_d.bin);
        w_d.full = (w_d.gray == {~w_q.rs2[PW-1:PW-2], w_q.rs2[PW-3:0]});
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_comb begin
        r_d     = r_q;
        r_d.ws1 = w_q.gray;
        r_d.ws2 = r_q.ws1;
        if (rd_en && !r_q.empty) r_d.bin = r_q.bin + PW'(1);
        r_d.gray  = to_gray(r_d.bin);
        r_d.empty = (r_d.gray == r_q.ws2);
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '{bin: '0, gray: '0, ws1: '0, ws2: '0, empty: 1'b1};
        else         r_q <= r_d;
    end

    assign full    = w_q.full;
    assign ovf_cnt = w_q.ovf;
    assign empty   = r_q.empty;
    assign rd_data = w_q.mem[r_q.bin[AW-1:0]];

    // R7: a write while full leaves the write pointer in place
    p_full_holds_ptr_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
        (full && wr_en) |=> $stable(w_q.bin));

    // R7: each dropped word adds one to the counter until it saturates
    p_ovf_step_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
        (full && wr_en && ovf_cnt != '1) |=> (ovf_cnt == $past(ovf_cnt) + CNT_W'(1)));

    // R9: a read on empty does not move the read pointer
    p_empty_read_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
        (empty && rd_en) |=> $stable(r_q.bin));
endmodule

// File: rtl/strip_fmt_top.sv
module strip_fmt_top
    import sbf_pkg::*;
#(
    parameter int FIFO_AW = 3,
    parameter int CNT_W   = 8
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              ev_start,
    input  logic              ev_end,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_err,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [BYTE_W-1:0] tbl_addr,
    input  logic [BYTE_W-1:0] tbl_wdata,
    output logic              wr_full,
    output logic [CNT_W-1:0]  ovf_count,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_empty
);
    logic        pair_vld;
    strip_word_t pair_word;
    logic        push;
    strip_word_t push_word;

    sbf_pair u_pair (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .ev_start (ev_start),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_err   (in_err),
        .out_vld  (pair_vld),
        .out_word (pair_word)
    );

    sbf_screen u_screen (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .ev_start  (ev_start),
        .ev_end    (ev_end),
        .tbl_we    (tbl_we),
        .tbl_sel   (tbl_sel),
        .tbl_addr  (tbl_addr),
        .tbl_wdata (tbl_wdata),
        .in_vld    (pair_vld),
        .in_word   (pair_word),
        .push      (push),
        .push_word (push_word)
    );

    sbf_afifo #(.W(WORD_W), .AW(FIFO_AW), .CNT_W(CNT_W)) u_fifo (
        .wclk    (wr_clk),
        .wrst_n  (wr_rst_n),
        .wr_en   (push),
        .wr_data (push_word),
        .full    (wr_full),
        .ovf_cnt (ovf_count),
        .rclk    (rd_clk),
        .rrst_n  (rd_rst_n),
        .rd_en   (rd_en),
        .rd_data (rd_word),
        .empty   (rd_empty)
    );
endmodule

// File: tb/sim_strip_fmt_top.sv
module sim_strip_fmt_top;
    localparam int WR_PERIOD = 20;
    localparam int RD_PERIOD = 32;
    localparam int DEPTH     = 8;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic ev_start = 1'b0, ev_end = 1'b0, in_valid = 1'b0, in_err = 1'b0;
    logic [7:0] in_byte = '0;
    logic tbl_we = 1'b0, tbl_sel = 1'b0;
    logic [7:0] tbl_addr = '0, tbl_wdata = '0;
    logic rd_en = 1'b0;
    logic wr_full, rd_empty;
    logic [7:0] ovf_count;
    logic [17:0] rd_word;

    strip_fmt_top u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .ev_start(ev_start), .ev_end(ev_end),
        .in_valid(in_valid), .in_byte(in_byte), .in_err(in_err),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .wr_full(wr_full), .ovf_count(ovf_count),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_word(rd_word), .rd_empty(rd_empty)
    );

    initial forever #(WR_PERIOD/2) wr_clk = ~wr_clk;
    initial forever #(RD_PERIOD/2) rd_clk = ~rd_clk;

    int total = 0, bad = 0;
    bit done = 1'b0;

    // behavioural model
    bit         bad_m [256];
    logic [7:0] gain_m [256];
    bit         act_m = 0, have_m = 0, ae_m = 0;
    logic [7:0] a_m = '0;
    logic [17:0] q[$];
    int ovf_m = 0;
    int delivered = 0;
    logic [17:0] last_seen = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin bad_m[i] = 0; gain_m[i] = '0; end
    end

    always @(posedge wr_clk) begin
        if (wr_rst_n) begin
            if (tbl_we && !act_m && !ev_start) begin
                if (tbl_sel) gain_m[tbl_addr] = tbl_wdata;
                else         bad_m[tbl_addr]  = tbl_wdata[0];
            end
            if (ev_start)    act_m = 1;
            else if (ev_end) act_m = 0;
            if (in_valid) begin
                if (ev_start || !have_m) begin
                    have_m = 1; a_m = in_byte; ae_m = in_err;
                end else begin
                    have_m = 0;
                    if (!bad_m[a_m]) begin
                        if (q.size() >= DEPTH) begin
                            if (ovf_m < 255) ovf_m++;
                        end else begin
                            q.push_back({ae_m, a_m, in_err, gain_m[a_m]});
                        end
                    end
                end
            end else if (ev_start) begin
                have_m = 0;
            end
        end
    end

    // read-side comparison on every read clock
    bit en_prev = 0, emp_prev = 1;
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (en_prev && !emp_prev && q.size() > 0) begin
                void'(q.pop_front());
                delivered++;
            end
            if (!rd_empty) begin
                total++;
                last_seen = rd_word;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R6 unexpected word: got %h expected none", rd_word);
                end else if (rd_word !== q[0]) begin
                    bad++;
                    $display("FAIL R3/R5/R6 word: got %h expected %h", rd_word, q[0]);
                end
            end
            en_prev  = rd_en;
            emp_prev = rd_empty;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drv(input logic v, input logic [7:0] b, input logic e,
                       input logic st, input logic en);
        @(negedge wr_clk);
        in_valid = v; in_byte = b; in_err = e; ev_start = st; ev_end = en; tbl_we = 0;
    endtask

    task automatic twr(input logic sel, input logic [7:0] a, input logic [7:0] d,
                       input logic st);
        @(negedge wr_clk);
        in_valid = 0; ev_start = st; ev_end = 0;
        tbl_we = 1; tbl_sel = sel; tbl_addr = a; tbl_wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) drv(0, 8'h00, 0, 0, 0);
    endtask

    task automatic strip(input logic [7:0] a, input logic ae,
                         input logic [7:0] d, input logic de);
        drv(1, a, ae, 0, 0);
        drv(1, d, de, 0, 0);
    endtask

    task automatic set_drain(input logic v);
        @(posedge rd_clk);
        #1 rd_en = v;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    int exp_cnt = 0;

    initial begin
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        idle(4);
        // R1 reset state
        chk("R1 empty", {31'd0, rd_empty}, 32'd1);
        chk("R1 full", {31'd0, wr_full}, 32'd0);
        chk("R1 ovf", {24'd0, ovf_count}, 32'd0);

        // R1: empty tables give compensated value 0 and no rejection
        set_drain(1);
        strip(8'h30, 0, 8'h99, 0); exp_cnt++;
        idle(40);
        chk("R1 zero gain word", {14'd0, last_seen}, {14'd0, 1'b0, 8'h30, 1'b0, 8'h00});

        // R8 load tables outside an event
        for (int i = 0; i < 16; i++) twr(1, i[7:0], 8'(i * 3 + 7), 0);
        twr(0, 8'h05, 8'h01, 0);
        twr(0, 8'h09, 8'h01, 0);
        idle(30);
        chk("R8 loading makes no words", {31'd0, rd_empty}, 32'd1);

        // event: strips 1..8, strip 5 is bad (R4), error flags (R3, R5)
        drv(0, 0, 0, 1, 0);
        for (int i = 1; i <= 8; i++) strip(i[7:0], i == 8, 8'(8'h40 + i), i == 3);
        exp_cnt += 7;
        idle(60);
        chk("R4 count after bad strip", delivered, exp_cnt);
        chk("R3/R5 last word", {14'd0, last_seen}, {14'd0, 1'b1, 8'h08, 1'b0, 8'h1F});

        // R2: start pulse with a byte while an address waits
        drv(1, 8'h03, 0, 0, 0);
        drv(1, 8'h04, 0, 1, 0);
        drv(1, 8'h66, 0, 0, 0); exp_cnt++;
        idle(40);
        chk("R2 restart with byte", {14'd0, last_seen}, {14'd0, 1'b0, 8'h04, 1'b0, 8'h13});
        // R2: bare start pulse drops a waiting address
        drv(1, 8'h06, 0, 0, 0);
        drv(0, 8'h00, 0, 1, 0);
        drv(1, 8'h07, 0, 0, 0);
        drv(1, 8'h22, 1, 0, 0); exp_cnt++;
        idle(40);
        chk("R2 dangling address dropped", {14'd0, last_seen}, {14'd0, 1'b0, 8'h07, 1'b1, 8'h1C});
        // R10: gaps between address and data
        drv(1, 8'h0A, 1, 0, 0);
        idle(3);
        drv(1, 8'h11, 0, 0, 0); exp_cnt++;
        idle(40);
        chk("R10 gaps ignored", {14'd0, last_seen}, {14'd0, 1'b1, 8'h0A, 1'b0, 8'h25});
        chk("R6 count", delivered, exp_cnt);

        // R8: writes during an event and with a start pulse are refused
        twr(1, 8'h02, 8'hAA, 0);
        twr(1, 8'h03, 8'hBB, 1);
        strip(8'h02, 0, 8'h01, 0);
        strip(8'h03, 0, 8'h01, 0); exp_cnt += 2;
        idle(40);
        chk("R8 locked write", {14'd0, last_seen}, {14'd0, 1'b0, 8'h03, 1'b0, 8'h10});
        drv(0, 0, 0, 0, 1);
        twr(1, 8'h02, 8'hAA, 0);
        strip(8'h02, 0, 8'h01, 0); exp_cnt++;
        idle(40);
        chk("R8 unlocked write", {14'd0, last_seen}, {14'd0, 1'b0, 8'h02, 1'b0, 8'hAA});
        twr(0, 8'h02, 8'h01, 0);
        strip(8'h02, 0, 8'h01, 0);
        strip(8'h03, 0, 8'h01, 0); exp_cnt++;
        idle(40);
        chk("R4/R8 new bad strip", delivered, exp_cnt);

        // R9: reads held high while empty
        idle(30);
        chk("R9 still empty", {31'd0, rd_empty}, 32'd1);
        strip(8'h01, 1, 8'h00, 1); exp_cnt++;
        idle(40);
        chk("R9 next word intact", {14'd0, last_seen}, {14'd0, 1'b1, 8'h01, 1'b1, 8'h0A});

        // R7: overflow with reads stopped
        set_drain(0);
        idle(20);
        drv(0, 0, 0, 1, 0);
        for (int i = 0; i < DEPTH + 3; i++) strip(8'(8'h40 + i), 0, 8'h00, 0);
        idle(4);
        chk("R7 full", {31'd0, wr_full}, 32'd1);
        chk("R7 drops", {24'd0, ovf_count}, 32'd3);
        for (int i = 0; i < 260; i++) strip(8'h50, 0, 8'h00, 0);
        idle(4);
        chk("R7 saturate", {24'd0, ovf_count}, 32'd255);
        chk("R7 model drops", ovf_m, 255);
        exp_cnt += DEPTH;
        set_drain(1);
        idle(80);
        chk("R6 drained", delivered, exp_cnt);
        chk("R7 full cleared", {31'd0, wr_full}, 32'd0);
        chk("R6 empty at end", {31'd0, rd_empty}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule